// File: doc/BRIEF.md
# Peripheral command channel engine

This block gives a host one register-mapped channel for issuing single transactions to a peripheral bus. The host first loads up to eight write bytes into two 32-bit data registers. It then writes a command word that packs an opcode, a 4-bit slave ID, a 16-bit register address and the byte count minus one. The engine decodes the word, checks the slave ID against a permission mask and drives one request on a simple request/response interface toward the peripheral side. For a read it captures the returned bytes into two read-data registers. It reports the outcome through a status register that the host polls.

Completion is signalled by a done bit. Three qualifier bits sit beside it: one for a failed transaction, one for a refused slave ID and one for a command dropped while the channel was busy. If the peripheral does not answer within a configurable number of cycles, the request is abandoned and reported as a failure.

Top module: `cmdch_engine`

## Requirements
- R1: After reset the status register reads 0, no request is driven, both read-data registers read 0 and the config register holds the PERMIT_RST parameter.
- R2: The registers sit at these offsets: command 0x00, config 0x04 (permission mask, bit n allows slave ID n), status 0x08, write data 0x10 (bytes 0-3) and 0x14 (bytes 4-7), read data 0x18 (bytes 0-3) and 0x1C (bytes 4-7). Config and write-data registers read back what was written, and any other offset reads 0.
- R3: A command word carries the opcode in bits 31:27, the slave ID in bits 23:20, the address in bits 19:4 and the byte count minus one in bits 2:0. An accepted command drives these fields on the request in the cycle after the command write. Opcodes 0, 2, 14 and 16 are writes (req_write_o=1) and opcodes 1, 13 and 15 are reads.
- R4: For a write, byte k of the request data sits in bits 8k+7:8k, taken from the write-data registers with byte 0 in the least significant lane. Lanes above the byte count are driven as zero.
- R5: On a successful read response, the read-data registers take the returned bytes, with every lane above the byte count zeroed. DONE is set in the same cycle.
- R6: Opcodes 3 to 6 are non-data commands. They are issued with req_write_o=0, and with address, byte count and request data all driven as zero.
- R7: Status bit 0 is DONE, bit 1 FAILURE, bit 2 DENIED and bit 3 DROPPED. An accepted command clears the status to 0 while it is outstanding, and a clean response leaves status 0x1.
- R8: An error response gives status 0x3 and leaves the read-data registers unchanged.
- R9: A command whose slave ID is not allowed by the config mask gives status 0x5 one cycle after the command write, and no request is issued.
- R10: A command write while a request is outstanding is ignored: the request fields and the command register do not change. The final status of the running transaction then has DROPPED set.
- R11: A request with no response after TIMEOUT_CYCLES cycles is withdrawn, the status becomes 0x3 and the read-data registers do not change.
- R12: Any opcode outside 0-6, 13-16 gives status 0x3 one cycle after the command write, and no request is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| req_valid_o | output | 1 | Request outstanding toward the peripheral |
| req_write_o | output | 1 | Request carries write data |
| req_opc_o | output | 5 | Request opcode |
| req_sid_o | output | 4 | Request slave ID |
| req_addr_o | output | 16 | Request register address |
| req_bc_o | output | 3 | Request byte count minus one |
| req_wdata_o | output | 64 | Request write data, byte 0 in bits 7:0 |
| rsp_valid_i | input | 1 | Response strobe for the outstanding request |
| rsp_err_i | input | 1 | Response reports an error |
| rsp_rdata_i | input | 64 | Response read data |

## Verification
A command write takes effect on the clock edge that samples it. The request fields are due in the following cycle, and the bench inspects them right after that edge. A response is sampled on the edge where rsp_valid_i is high, and the status and read-data registers carry its result immediately after that same edge. Refused and unsupported commands finish on the command edge itself. A silent request is withdrawn exactly TIMEOUT_CYCLES edges after the command, so the bench checks it still outstanding one edge earlier and complete at that edge. All stimulus changes and all register reads happen at the falling edge, half a period away from every sampling edge.

// File: rtl/cmdch_pkg.sv
package cmdch_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned OPC_W  = 5;
  localparam int unsigned SID_W  = 4;
  localparam int unsigned NSID   = 1 << SID_W;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned NBYTES = 8;
  localparam int unsigned BC_W   = $clog2(NBYTES);
  localparam int unsigned DATA_W = 8 * NBYTES;
  localparam int unsigned STAT_W = 4;

  // command word field positions
  localparam int unsigned OPC_LSB  = 27;
  localparam int unsigned SID_LSB  = 20;
  localparam int unsigned ADDR_LSB = 4;

  localparam logic [REG_AW-1:0] OFS_CMD  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CFG  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_STAT = 5'h08;
  localparam logic [REG_AW-1:0] OFS_WD0  = 5'h10;
  localparam logic [REG_AW-1:0] OFS_WD1  = 5'h14;
  localparam logic [REG_AW-1:0] OFS_RD0  = 5'h18;
  localparam logic [REG_AW-1:0] OFS_RD1  = 5'h1C;

  typedef enum logic [1:0] {K_WRITE, K_READ, K_NODATA, K_BAD} kind_e;

  typedef struct packed {
    logic drop;
    logic deny;
    logic fail;
    logic done;
  } stat_t;
endpackage

// File: rtl/cmdch_lane_mask.sv
module cmdch_lane_mask #(
  parameter int unsigned NBYTES = 8,
  localparam int unsigned BC_W = $clog2(NBYTES)
) (
  input  logic [BC_W-1:0]     bc_i,
  output logic [8*NBYTES-1:0] mask_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam logic [BC_W-1:0] LANE = BC_W'(g);
    assign mask_o[8*g +: 8] = {8{bc_i >= LANE}};
  end
endmodule

// File: rtl/cmdch_decode.sv
module cmdch_decode
  import cmdch_pkg::*;
(
  input  logic [31:0]       cmd_i,
  input  logic [NSID-1:0]   permit_i,
  output kind_e             kind_o,
  output logic              deny_o,
  output logic [OPC_W-1:0]  opc_o,
  output logic [SID_W-1:0]  sid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BC_W-1:0]   bc_o
);
  logic [OPC_W-1:0] opc;
  logic unused_bits;

  assign opc         = cmd_i[OPC_LSB +: OPC_W];
  assign opc_o       = opc;
  assign sid_o       = cmd_i[SID_LSB +: SID_W];
  assign deny_o      = ~permit_i[sid_o];
  assign unused_bits = ^{cmd_i[26:24], cmd_i[3]};

  always_comb begin
    unique case (opc)
      5'd0, 5'd2, 5'd14, 5'd16: kind_o = K_WRITE;
      5'd1, 5'd13, 5'd15:       kind_o = K_READ;
      5'd3, 5'd4, 5'd5, 5'd6:   kind_o = K_NODATA;
      default:                  kind_o = K_BAD;
    endcase
  end

  // non-data commands carry no address or count
  assign addr_o = (kind_o == K_NODATA) ? '0 : cmd_i[ADDR_LSB +: ADDR_W];
  assign bc_o   = (kind_o == K_NODATA) ? '0 : cmd_i[BC_W-1:0];
endmodule

// File: rtl/cmdch_ctrl.sv
module cmdch_ctrl
  import cmdch_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  kind_e             kind_i,
  input  logic              deny_i,
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [SID_W-1:0]  sid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BC_W-1:0]   bc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rd_mask_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic [OPC_W-1:0]  req_opc_o,
  output logic [SID_W-1:0]  req_sid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [BC_W-1:0]   req_bc_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output stat_t             stat_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic              busy_q, is_rd_q, wr_q, drop_q, drop_now;
  logic [OPC_W-1:0]  opc_q;
  logic [SID_W-1:0]  sid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BC_W-1:0]   bc_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CNT_W-1:0]  cnt_q;
  stat_t             stat_q;

  // a command arriving in the completing cycle is also dropped
  assign drop_now = drop_q | start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      wr_q    <= 1'b0;
      drop_q  <= 1'b0;
      opc_q   <= '0;
      sid_q   <= '0;
      addr_q  <= '0;
      bc_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
      stat_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        drop_q <= 1'b0;
        cnt_q  <= '0;
        if (kind_i == K_BAD) begin
          stat_q <= '{drop: 1'b0, deny: 1'b0, fail: 1'b1, done: 1'b1};
        end else if (deny_i) begin
          stat_q <= '{drop: 1'b0, deny: 1'b1, fail: 1'b0, done: 1'b1};
        end else begin
          stat_q  <= '0;
          busy_q  <= 1'b1;
          is_rd_q <= (kind_i == K_READ);
          wr_q    <= (kind_i == K_WRITE);
          opc_q   <= opc_i;
          sid_q   <= sid_i;
          addr_q  <= addr_i;
          bc_q    <= bc_i;
          wdata_q <= (kind_i == K_WRITE) ? wdata_i : '0;
        end
      end
    end else begin
      if (start_i) drop_q <= 1'b1;
      if (rsp_valid_i) begin
        busy_q <= 1'b0;
        stat_q <= '{drop: drop_now, deny: 1'b0, fail: rsp_err_i, done: 1'b1};
        if (is_rd_q && !rsp_err_i) rdata_q <= rsp_rdata_i & rd_mask_i;
      end else if (cnt_q == CNT_LAST) begin
        busy_q <= 1'b0;
        stat_q <= '{drop: drop_now, deny: 1'b0, fail: 1'b1, done: 1'b1};
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign req_valid_o = busy_q;
  assign req_write_o = wr_q;
  assign req_opc_o   = opc_q;
  assign req_sid_o   = sid_q;
  assign req_addr_o  = addr_q;
  assign req_bc_o    = bc_q;
  assign req_wdata_o = wdata_q;
  assign stat_o      = stat_q;
  assign rdata_o     = rdata_q;

  AST_DENY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !req_valid_o && kind_i != K_BAD && deny_i) |=> (!req_valid_o && stat_o.deny && stat_o.done)); // R9
  AST_BAD_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !req_valid_o && kind_i == K_BAD) |=> (!req_valid_o && stat_o.fail && !stat_o.deny)); // R12
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && start_i && !rsp_valid_i && cnt_q != CNT_LAST) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_sid_o) && $stable(req_opc_o))); // R10
  AST_RSP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && rsp_valid_i) |=> (stat_o.done && !req_valid_o)); // R7
  AST_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !rsp_valid_i && cnt_q == CNT_LAST) |=> (stat_o.done && stat_o.fail && !req_valid_o)); // R11
  AST_RD_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && rsp_valid_i && is_rd_q && !rsp_err_i) |=> ((rdata_o & ~rd_mask_i) == '0)); // R5
endmodule

// File: rtl/cmdch_engine.sv
module cmdch_engine
  import cmdch_pkg::*;
#(
  parameter int unsigned     TIMEOUT_CYCLES = 5000,
  parameter logic [NSID-1:0] PERMIT_RST     = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic [OPC_W-1:0]  req_opc_o,
  output logic [SID_W-1:0]  req_sid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [BC_W-1:0]   req_bc_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic [DATA_W-1:0] rsp_rdata_i
);
  logic [31:0]       cmd_q, wd0_q, wd1_q;
  logic [NSID-1:0]   permit_q;
  logic              cmd_hit;
  kind_e             dec_kind;
  logic              dec_deny;
  logic [OPC_W-1:0]  dec_opc;
  logic [SID_W-1:0]  dec_sid;
  logic [ADDR_W-1:0] dec_addr;
  logic [BC_W-1:0]   dec_bc;
  logic [DATA_W-1:0] wr_mask, rd_mask, rdata;
  stat_t             stat;

  assign cmd_hit = reg_we_i && (reg_addr_i == OFS_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      wd0_q    <= '0;
      wd1_q    <= '0;
      permit_q <= PERMIT_RST;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        OFS_CMD: if (!req_valid_o) cmd_q <= reg_wdata_i;
        OFS_CFG: permit_q <= reg_wdata_i[NSID-1:0];
        OFS_WD0: wd0_q <= reg_wdata_i;
        OFS_WD1: wd1_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_CMD:  reg_rdata_o = cmd_q;
      OFS_CFG:  reg_rdata_o = {{(32-NSID){1'b0}}, permit_q};
      OFS_STAT: reg_rdata_o = {{(32-STAT_W){1'b0}}, stat};
      OFS_WD0:  reg_rdata_o = wd0_q;
      OFS_WD1:  reg_rdata_o = wd1_q;
      OFS_RD0:  reg_rdata_o = rdata[31:0];
      OFS_RD1:  reg_rdata_o = rdata[63:32];
      default:  reg_rdata_o = '0;
    endcase
  end

  cmdch_decode u_decode (
    .cmd_i    (reg_wdata_i),
    .permit_i (permit_q),
    .kind_o   (dec_kind),
    .deny_o   (dec_deny),
    .opc_o    (dec_opc),
    .sid_o    (dec_sid),
    .addr_o   (dec_addr),
    .bc_o     (dec_bc)
  );

  cmdch_lane_mask #(.NBYTES(NBYTES)) u_wr_mask (.bc_i(dec_bc),   .mask_o(wr_mask));
  cmdch_lane_mask #(.NBYTES(NBYTES)) u_rd_mask (.bc_i(req_bc_o), .mask_o(rd_mask));

  cmdch_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cmd_hit),
    .kind_i      (dec_kind),
    .deny_i      (dec_deny),
    .opc_i       (dec_opc),
    .sid_i       (dec_sid),
    .addr_i      (dec_addr),
    .bc_i        (dec_bc),
    .wdata_i     ({wd1_q, wd0_q} & wr_mask),
    .rd_mask_i   (rd_mask),
    .rsp_valid_i (rsp_valid_i),
    .rsp_err_i   (rsp_err_i),
    .rsp_rdata_i (rsp_rdata_i),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_opc_o   (req_opc_o),
    .req_sid_o   (req_sid_o),
    .req_addr_o  (req_addr_o),
    .req_bc_o    (req_bc_o),
    .req_wdata_o (req_wdata_o),
    .stat_o      (stat),
    .rdata_o     (rdata)
  );

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && cmd_hit) |=> $stable(cmd_q)); // R10
  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_hit && !req_valid_o && dec_kind != K_BAD && !dec_deny) |=> (req_valid_o && stat == '0)); // R7
endmodule

// File: tb/test_cmdch_engine.sv
module test_cmdch_engine;
  import cmdch_pkg::*;

  localparam int unsigned TMO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_write;
  logic [4:0]  req_opc;
  logic [3:0]  req_sid;
  logic [15:0] req_addr;
  logic [2:0]  req_bc;
  logic [63:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic        rsp_err = 1'b0;
  logic [63:0] rsp_rdata = '0;

  int          nvec = 0;
  int          nfail = 0;
  logic [15:0] permit_m = 16'hFFFF;
  logic [63:0] exp_rd = '0;

  always #10 clk = ~clk;

  cmdch_engine #(.TIMEOUT_CYCLES(TMO), .PERMIT_RST(16'hFFFF)) i_cmdch_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_valid_o(req_valid),
    .req_write_o(req_write), .req_opc_o(req_opc), .req_sid_o(req_sid),
    .req_addr_o(req_addr), .req_bc_o(req_bc), .req_wdata_o(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err), .rsp_rdata_i(rsp_rdata)
  );

  function automatic logic [63:0] lane_mask(input logic [2:0] bc);
    logic [63:0] m = '0;
    for (int i = 0; i < 8; i++) if (i <= int'(bc)) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  // 0 write, 1 read, 2 non-data, 3 unsupported
  function automatic int kind_of(input logic [4:0] op);
    if (op == 0 || op == 2 || op == 14 || op == 16) return 0;
    if (op == 1 || op == 13 || op == 15) return 1;
    if (op >= 3 && op <= 6) return 2;
    return 3;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic respond(input logic err, input logic [63:0] d, input int dly);
    repeat (dly) @(negedge clk);
    rsp_valid = 1'b1; rsp_err = err; rsp_rdata = d;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0;
  endtask

  task automatic chk_rdata(input string tag);
    logic [31:0] v;
    rd(OFS_RD0, v); chk(tag, 64'(v), 64'(exp_rd[31:0]));
    rd(OFS_RD1, v); chk(tag, 64'(v), 64'(exp_rd[63:32]));
  endtask

  task automatic do_cmd(input logic [4:0] op, input logic [3:0] sid, input logic [15:0] addr,
                        input logic [2:0] bc, input logic [63:0] wd, input logic err,
                        input int dly, input logic [63:0] rsp);
    int k;
    logic [63:0] m;
    logic [31:0] v;
    k = kind_of(op);
    m = lane_mask(bc);
    wr(OFS_WD0, wd[31:0]);
    wr(OFS_WD1, wd[63:32]);
    wr(OFS_CMD, {op, 3'b000, sid, addr, 1'b0, bc});
    if (k == 3 || !permit_m[sid]) begin
      rd(OFS_STAT, v);
      if (k == 3) chk("R12 unsupported opcode status", 64'(v), 64'h3);
      else        chk("R9 denied status", 64'(v), 64'h5);
      chk("R9 R12 no request", 64'(req_valid), 64'h0);
    end else begin
      chk("R3 request valid", 64'(req_valid), 64'h1);
      chk("R3 opcode", 64'(req_opc), 64'(op));
      chk("R3 slave id", 64'(req_sid), 64'(sid));
      if (k == 2) begin
        chk("R6 address zero", 64'(req_addr), 64'h0);
        chk("R6 count zero", 64'(req_bc), 64'h0);
        chk("R6 no write flag", 64'(req_write), 64'h0);
        chk("R6 data zero", req_wdata, 64'h0);
      end else begin
        chk("R3 address", 64'(req_addr), 64'(addr));
        chk("R3 byte count", 64'(req_bc), 64'(bc));
        chk("R3 write flag", 64'(req_write), (k == 0) ? 64'h1 : 64'h0);
        if (k == 0) chk("R4 write data packing", req_wdata, wd & m);
      end
      rd(OFS_STAT, v);
      chk("R7 status cleared while busy", 64'(v), 64'h0);
      respond(err, rsp, dly);
      rd(OFS_STAT, v);
      if (err) chk("R8 error status", 64'(v), 64'h3);
      else     chk("R7 done status", 64'(v), 64'h1);
      if (k == 1 && !err) exp_rd = rsp & m;
      chk_rdata(err ? "R8 read data kept" : "R5 read data");
      chk("R7 request withdrawn", 64'(req_valid), 64'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [4:0] ops [12] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6,
                             5'd13, 5'd14, 5'd15, 5'd16, 5'd15};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 no request in reset", 64'(req_valid), 64'h0);
    rd(OFS_STAT, v); chk("R1 status at reset", 64'(v), 64'h0);
    rd(OFS_CFG, v);  chk("R1 config at reset", 64'(v), 64'hFFFF);
    chk_rdata("R1 read data at reset");
    rst_n = 1'b1;

    // R2 register map
    wr(OFS_CFG, 32'h1234A5F3); permit_m = 16'hA5F3;
    rd(OFS_CFG, v); chk("R2 config readback", 64'(v), 64'hA5F3);
    wr(OFS_WD0, 32'hCAFEF00D);
    rd(OFS_WD0, v); chk("R2 wdata0 readback", 64'(v), 64'hCAFEF00D);
    wr(OFS_WD1, 32'h0BADBEEF);
    rd(OFS_WD1, v); chk("R2 wdata1 readback", 64'(v), 64'h0BADBEEF);
    rd(5'h0C, v);   chk("R2 unmapped offset", 64'(v), 64'h0);

    // directed cases
    do_cmd(5'd14, 4'd0, 16'h1234, 3'd7, 64'h8877665544332211, 1'b0, 2, 64'h0);
    do_cmd(5'd2,  4'd1, 16'h00AB, 3'd2, 64'hFFFFFFFFFFFFFFFF, 1'b0, 0, 64'h0);
    do_cmd(5'd15, 4'd1, 16'h0040, 3'd0, 64'h0, 1'b0, 1, 64'hDEADBEEF01234567);
    do_cmd(5'd13, 4'd4, 16'h0F10, 3'd3, 64'h0, 1'b0, 3, 64'hA1A2A3A4A5A6A7A8);
    do_cmd(5'd1,  4'd15, 16'hFFFF, 3'd7, 64'h0, 1'b0, 0, 64'h0102030405060708);
    do_cmd(5'd3,  4'd4, 16'hFFFF, 3'd7, 64'h55AA55AA55AA55AA, 1'b0, 1, 64'h0);
    do_cmd(5'd16, 4'd5, 16'h0000, 3'd0, 64'h000000000000007F, 1'b0, 0, 64'h0);
    do_cmd(5'd15, 4'd6, 16'h0101, 3'd5, 64'h0, 1'b1, 2, 64'h1111111111111111);
    do_cmd(5'd14, 4'd6, 16'h0202, 3'd1, 64'h9999, 1'b1, 0, 64'h0);
    do_cmd(5'd15, 4'd2, 16'h0303, 3'd1, 64'h0, 1'b0, 0, 64'h0);
    do_cmd(5'd7,  4'd0, 16'h0404, 3'd0, 64'h0, 1'b0, 0, 64'h0);
    do_cmd(5'd31, 4'd0, 16'h0505, 3'd0, 64'h0, 1'b0, 0, 64'h0);

    // R10 command while busy
    wr(OFS_CMD, {5'd15, 3'b000, 4'd0, 16'h0010, 1'b0, 3'd1});
    chk("R10 first request issued", 64'(req_valid), 64'h1);
    wr(OFS_CMD, {5'd14, 3'b000, 4'd1, 16'hBEEF, 1'b0, 3'd0});
    chk("R10 request still out", 64'(req_valid), 64'h1);
    chk("R10 address held", 64'(req_addr), 64'h0010);
    chk("R10 opcode held", 64'(req_opc), 64'd15);
    rd(OFS_CMD, v);
    chk("R10 command register held", 64'(v), 64'({5'd15, 3'b000, 4'd0, 16'h0010, 1'b0, 3'd1}));
    respond(1'b0, 64'hFEDCBA9876543210, 1);
    rd(OFS_STAT, v); chk("R10 dropped flag", 64'(v), 64'h9);
    exp_rd = 64'h3210;
    chk_rdata("R10 R5 read data of first command");

    // R11 timeout
    wr(OFS_CMD, {5'd1, 3'b000, 4'd0, 16'h0777, 1'b0, 3'd2});
    repeat (TMO - 1) @(negedge clk);
    chk("R11 still waiting", 64'(req_valid), 64'h1);
    rd(OFS_STAT, v); chk("R11 status before expiry", 64'(v), 64'h0);
    @(negedge clk);
    chk("R11 request withdrawn", 64'(req_valid), 64'h0);
    rd(OFS_STAT, v); chk("R11 timeout status", 64'(v), 64'h3);
    chk_rdata("R11 read data kept");

    // random mix
    for (int n = 0; n < 150; n++) begin
      int r;
      logic [4:0] op;
      r = int'($urandom % 16);
      if (r < 12) op = ops[r];
      else if (r == 12) op = 5'd7;
      else if (r == 13) op = 5'd9;
      else if (r == 14) op = 5'd17;
      else op = 5'(17 + $urandom % 15);
      do_cmd(op, 4'($urandom), 16'($urandom), 3'($urandom),
             {$urandom, $urandom}, ($urandom % 5) == 0, int'($urandom % 6),
             {$urandom, $urandom});
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule